// File: doc/BRIEF.md
# Core Clock Frequency Change Sequencer

This block runs the hardware side of a core clock frequency change. Software writes a clock configuration word holding a change-request bit, a turbo-select bit and a core ratio field. When the change bit is set while the block is idle, the sequencer stops the CPU clock and holds back interrupts, DMA requests and imprecise-abort events. It then asks the memory controller to drain its pending work, commands SDRAM into self-refresh, and tells the PLL to relock. After lock has held for a settle interval, it brings SDRAM out of self-refresh, restarts the clock and returns to idle.

The turbo selection and the ratio written with the request are stored at once but take effect only when the sequence exits. Supply-fault and battery-fault indications pass straight through to a sleep request while idle. During a change they are held back, remembered, and replayed as a single sleep-request pulse on the first idle cycle. A lock timeout raises a sticky error flag, and the sequencer keeps waiting for lock.

Top module: `freq_change_seq`

## Requirements
- R1: A write (`cfg_wr`=1) whose bit 0 (change request) is 1, made while `busy`=0, starts the sequence. On the following cycle `busy`=1 and `cpu_clk_en`=0.
- R2: Bit 1 (turbo) and bits 6:2 (ratio) of any write accepted while idle are stored in `cfg_q` at once. `turbo_en` and `core_ratio` take those values only on the cycle `busy` falls at the end of a sequence. A write with bit 0 clear leaves them unchanged.
- R3: While `busy`=1, `irq_out`, `dma_out` and `abort_out` are all 0. `cpu_clk_en` stays 0 from the first busy cycle up to the last one, and is 1 again on that last busy cycle. Once idle, the three outputs follow their inputs.
- R4: After the gate cycle, `drain_req` stays 1 until `drain_ack` is seen. `sr_req` rises only on the cycle after `drain_ack` was 1.
- R5: `sr_req` stays 1 until the relock completes. `pll_relock` is 1 only once `sr_ack` has been seen. After `sr_req` falls, the clock stays stopped until `sr_ack` returns to 0.
- R6: `sr_req` falls after `pll_lock` has been 1 for SETTLE_CYC consecutive cycles during relock (16 by default). A drop of `pll_lock` restarts the count.
- R7: If `pll_lock` stays 0 for TIMEOUT_CYC cycles of relock (256 by default), `lock_err` becomes 1 and stays 1 until reset. The sequence still completes once lock arrives.
- R8: While idle, `sleep_req` equals `supply_fault` OR `battery_fault`. While busy, `sleep_req` is 0. A fault seen at any point during the sequence gives exactly one `sleep_req` cycle, on the first idle cycle.
- R9: Bit 0 of `cfg_q` clears when the sequence returns to idle. `busy` stays high until then. Writes made while busy change nothing.
- R10: After reset: `busy`=0, `cpu_clk_en`=1, `drain_req`=`sr_req`=`pll_relock`=0, `lock_err`=0, `cfg_q`=0, `turbo_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Write data: bit 0 change, bit 1 turbo, bits 6:2 ratio |
| cfg_q | output | 7 | Stored configuration word |
| busy | output | 1 | Frequency change in progress |
| turbo_en | output | 1 | Applied turbo selection |
| core_ratio | output | 5 | Applied core ratio |
| cpu_clk_en | output | 1 | CPU clock enable |
| drain_req | output | 1 | Ask memory controller to finish pending transactions |
| drain_ack | input | 1 | Drain complete |
| sr_req | output | 1 | Hold SDRAM in self-refresh |
| sr_ack | input | 1 | SDRAM is in self-refresh |
| pll_relock | output | 1 | PLL may relock to the new ratio |
| pll_lock | input | 1 | PLL lock indication |
| lock_err | output | 1 | Sticky lock timeout flag |
| irq_in | input | 8 | Interrupt requests from sources |
| irq_out | output | 8 | Interrupt requests to the CPU |
| dma_in | input | 4 | DMA requests from peripherals |
| dma_out | output | 4 | DMA requests to the DMA engine |
| abort_in | input | 1 | Imprecise data abort event |
| abort_out | output | 1 | Imprecise abort passed to the CPU |
| supply_fault | input | 1 | Supply fault, active high |
| battery_fault | input | 1 | Battery fault, active high |
| sleep_req | output | 1 | Request to enter sleep |

## Verification
The assertions assume the memory controller follows a four-phase handshake. `drain_ack` is raised only while `drain_req` is high. `sr_ack` rises only after `sr_req` rises and falls only after `sr_req` falls. The bench acts as that controller: it raises each acknowledge only after sampling the matching request, and drops it only after the request has moved on. `pll_lock` is driven only in the relock phase or at idle. Fault pulses are kept short, so that a latched fault and a fault still asserted are seen apart.

// File: rtl/fcs_pkg.sv
// Shared definitions for the frequency change sequencer.
// Assumes: the configuration word layout below is fixed by software.
package fcs_pkg;
    localparam int RATIO_W   = 5;
    localparam int CFG_W     = 2 + RATIO_W;
    localparam int CHG_BIT   = 0;
    localparam int TURBO_BIT = 1;
    localparam int RATIO_LSB = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GATE    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_SREF    = 3'd3,
        ST_RELOCK  = 3'd4,
        ST_SR_EXIT = 3'd5,
        ST_RESUME  = 3'd6
    } fcs_state_t;
endpackage

// File: rtl/fcs_timer.sv
// Settle and timeout counters for the PLL relock phase.
// Assumes: in_wait is high exactly while the sequencer waits for lock.
// lock_ok pulses once lock has been held SETTLE_CYC cycles in a row.
// lock_err is sticky until reset.
module fcs_timer #(
    parameter int SETTLE_CYC  = 16,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    input  logic pll_lock,
    output logic lock_ok,
    output logic lock_err
);
    localparam int SW = (SETTLE_CYC  > 2) ? $clog2(SETTLE_CYC)  : 1;
    localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    logic [SW-1:0] settle_cnt;
    logic [TW-1:0] wait_cnt;
    logic          counting;
    logic          settle_last;
    logic          err_q;

    assign counting    = in_wait && pll_lock;
    assign settle_last = (settle_cnt == S_LAST);
    assign lock_ok     = counting && settle_last;
    assign lock_err    = err_q;

    // Count consecutive locked cycles; any lock drop restarts the count
    always_ff @(posedge clk) begin
        if (!rst_n || !counting || settle_last) settle_cnt <= '0;
        else                                    settle_cnt <= settle_cnt + 1'b1;
    end

    // Count unlocked cycles in relock, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait || pll_lock) wait_cnt <= '0;
        else if (wait_cnt != T_LAST)        wait_cnt <= wait_cnt + 1'b1;
    end

    // Sticky timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n)                                         err_q <= 1'b0;
        else if (in_wait && !pll_lock && wait_cnt == T_LAST) err_q <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_err) |-> lock_err); // R7
    AST_SETTLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> $past(pll_lock) && $past(in_wait)); // R6
endmodule

// File: rtl/fcs_hold.sv
// Holds back interrupt, DMA, abort and fault events while a change runs.
// Assumes: busy is registered and clean. Faults seen while busy are latched
// and replayed as one sleep-request cycle on the first idle cycle.
module fcs_hold #(
    parameter int N_IRQ = 8,
    parameter int N_DMA = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_DMA-1:0] dma_in,
    input  logic             abort_in,
    input  logic             supply_fault,
    input  logic             battery_fault,
    output logic [N_IRQ-1:0] irq_out,
    output logic [N_DMA-1:0] dma_out,
    output logic             abort_out,
    output logic             sleep_req
);
    logic fault_any;
    logic fault_pend;
    logic busy_q;
    logic exit_cycle;

    assign fault_any  = supply_fault || battery_fault;
    assign exit_cycle = busy_q && !busy;

    // Mask requests to the CPU and DMA engine during the change
    always_comb begin
        irq_out   = busy ? '0 : irq_in;
        dma_out   = busy ? '0 : dma_in;
        abort_out = !busy && abort_in;
    end

    // Track the previous busy value to find the exit cycle
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Remember any fault seen while busy until it is replayed
    always_ff @(posedge clk) begin
        if (!rst_n)                 fault_pend <= 1'b0;
        else if (busy && fault_any) fault_pend <= 1'b1;
        else if (exit_cycle)        fault_pend <= 1'b0;
    end

    // Pass faults through when idle and replay the latched one on exit
    always_comb begin
        sleep_req = !busy && (fault_any || (exit_cycle && fault_pend));
    end

    AST_NO_SLEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sleep_req); // R8
    AST_PEND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_cycle |=> !fault_pend); // R8
    AST_HELD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (irq_out == '0) && (dma_out == '0) && !abort_out); // R3
endmodule

// File: rtl/fcs_fsm.sv
// Sequencing state machine: clock gate, drain, self-refresh, relock, exit.
// Assumes: the memory controller uses level req/ack pairs, and lock_ok comes
// from the settle timer. Holds the configuration word and applies the
// turbo and ratio fields only on exit.
module fcs_fsm
    import fcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               drain_ack,
    input  logic               sr_ack,
    input  logic               pll_lock,
    input  logic               lock_ok,
    output logic [CFG_W-1:0]   cfg_q,
    output logic               busy,
    output logic               turbo_en,
    output logic [RATIO_W-1:0] core_ratio,
    output logic               cpu_clk_en,
    output logic               drain_req,
    output logic               sr_req,
    output logic               pll_relock,
    output logic               in_wait
);
    fcs_state_t state, state_nx;
    logic       start;

    assign start = cfg_wr && cfg_wdata[CHG_BIT] && (state == ST_IDLE);

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start)     state_nx = ST_GATE;
            ST_GATE:                   state_nx = ST_DRAIN;
            ST_DRAIN:   if (drain_ack) state_nx = ST_SREF;
            ST_SREF:    if (sr_ack)    state_nx = ST_RELOCK;
            ST_RELOCK:  if (lock_ok)   state_nx = ST_SR_EXIT;
            ST_SR_EXIT: if (!sr_ack)   state_nx = ST_RESUME;
            ST_RESUME:                 state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Configuration word: written only while idle; change bit self-clears on exit
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (cfg_wr && state == ST_IDLE)    cfg_q <= cfg_wdata;
        else if (state == ST_RESUME)            cfg_q[CHG_BIT] <= 1'b0;
    end

    // Apply turbo and ratio at the moment the sequence exits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turbo_en   <= 1'b0;
            core_ratio <= '0;
        end else if (state == ST_RESUME) begin
            turbo_en   <= cfg_q[TURBO_BIT];
            core_ratio <= cfg_q[RATIO_LSB +: RATIO_W];
        end
    end

    // Decode handshake and clock controls from the state
    always_comb begin
        busy       = (state != ST_IDLE);
        cpu_clk_en = (state == ST_IDLE) || (state == ST_RESUME);
        drain_req  = (state == ST_DRAIN);
        sr_req     = (state == ST_SREF) || (state == ST_RELOCK);
        pll_relock = (state == ST_RELOCK);
        in_wait    = (state == ST_RELOCK);
    end

    AST_START_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !cpu_clk_en); // R1
    AST_SR_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_req) |-> $past(drain_ack)); // R4
    AST_RELOCK_AFTER_SR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_relock) |-> $past(sr_ack)); // R5
    AST_EXIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_req) |-> $past(pll_lock) && $past(lock_ok)); // R6
    AST_TURBO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(turbo_en) && $stable(core_ratio)); // R2
    AST_CHG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cfg_q[CHG_BIT]); // R9
    AST_BUSY_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(state == ST_RESUME) |-> $stable(cfg_q)); // R9
endmodule

// File: rtl/freq_change_seq.sv
// Top level of the core clock frequency change sequencer.
// Assumes: a single clock domain, synchronous active-low reset, and a memory
// controller and PLL driving level acknowledges. Connects the state machine,
// the relock timers and the event hold logic.
module freq_change_seq
    import fcs_pkg::*;
#(
    parameter int SETTLE_CYC  = 16,
    parameter int TIMEOUT_CYC = 256,
    parameter int N_IRQ       = 8,
    parameter int N_DMA       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_q,
    output logic               busy,
    output logic               turbo_en,
    output logic [RATIO_W-1:0] core_ratio,
    output logic               cpu_clk_en,
    output logic               drain_req,
    input  logic               drain_ack,
    output logic               sr_req,
    input  logic               sr_ack,
    output logic               pll_relock,
    input  logic               pll_lock,
    output logic               lock_err,
    input  logic [N_IRQ-1:0]   irq_in,
    output logic [N_IRQ-1:0]   irq_out,
    input  logic [N_DMA-1:0]   dma_in,
    output logic [N_DMA-1:0]   dma_out,
    input  logic               abort_in,
    output logic               abort_out,
    input  logic               supply_fault,
    input  logic               battery_fault,
    output logic               sleep_req
);
    logic in_wait;
    logic lock_ok;

    fcs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .drain_ack  (drain_ack),
        .sr_ack     (sr_ack),
        .pll_lock   (pll_lock),
        .lock_ok    (lock_ok),
        .cfg_q      (cfg_q),
        .busy       (busy),
        .turbo_en   (turbo_en),
        .core_ratio (core_ratio),
        .cpu_clk_en (cpu_clk_en),
        .drain_req  (drain_req),
        .sr_req     (sr_req),
        .pll_relock (pll_relock),
        .in_wait    (in_wait)
    );

    fcs_timer #(
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_wait  (in_wait),
        .pll_lock (pll_lock),
        .lock_ok  (lock_ok),
        .lock_err (lock_err)
    );

    fcs_hold #(
        .N_IRQ (N_IRQ),
        .N_DMA (N_DMA)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy),
        .irq_in        (irq_in),
        .dma_in        (dma_in),
        .abort_in      (abort_in),
        .supply_fault  (supply_fault),
        .battery_fault (battery_fault),
        .irq_out       (irq_out),
        .dma_out       (dma_out),
        .abort_out     (abort_out),
        .sleep_req     (sleep_req)
    );
endmodule

// File: tb/test_freq_change_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module test_freq_change_seq;
    localparam int SETTLE = 16;
    localparam int TMO    = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [6:0] cfg_q;
    logic       busy, turbo_en, cpu_clk_en, drain_req, sr_req, pll_relock, lock_err;
    logic [4:0] core_ratio;
    logic       drain_ack = 1'b0, sr_ack = 1'b0, pll_lock = 1'b0;
    logic [7:0] irq_in = '0, irq_out;
    logic [3:0] dma_in = '0, dma_out;
    logic       abort_in = 1'b0, abort_out;
    logic       supply_fault = 1'b0, battery_fault = 1'b0, sleep_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    freq_change_seq i_freq_change_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .busy(busy), .turbo_en(turbo_en), .core_ratio(core_ratio),
        .cpu_clk_en(cpu_clk_en), .drain_req(drain_req), .drain_ack(drain_ack),
        .sr_req(sr_req), .sr_ack(sr_ack), .pll_relock(pll_relock),
        .pll_lock(pll_lock), .lock_err(lock_err), .irq_in(irq_in),
        .irq_out(irq_out), .dma_in(dma_in), .dma_out(dma_out),
        .abort_in(abort_in), .abort_out(abort_out), .supply_fault(supply_fault),
        .battery_fault(battery_fault), .sleep_req(sleep_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R10: values straight after reset
    task automatic t_reset;
        chk("R10", "busy", 32'(busy), 0);
        chk("R10", "cpu_clk_en", 32'(cpu_clk_en), 1);
        chk("R10", "drain/sr/relock", {29'd0, drain_req, sr_req, pll_relock}, 0);
        chk("R10", "lock_err", 32'(lock_err), 0);
        chk("R10", "cfg_q", 32'(cfg_q), 0);
        chk("R10", "turbo_en", 32'(turbo_en), 0);
    endtask

    // R2, R8: idle write without change bit, idle fault pass-through
    task automatic t_idle;
        logic [6:0] wd = 7'b0101010;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = wd;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R2", "no start", 32'(busy), 0);
        chk("R2", "cfg stored", 32'(cfg_q), 32'(wd));
        chk("R2", "turbo not applied", 32'(turbo_en), 0);
        battery_fault = 1'b1; #1;
        chk("R8", "idle fault passes", 32'(sleep_req), 1);
        @(negedge clk); battery_fault = 1'b0; #1;
        chk("R8", "idle fault gone", 32'(sleep_req), 0);
    endtask

    // mode 0 plain, 1 write while busy, 2 fault, 3 lock glitch, 4 timeout
    task automatic t_seq(input logic [6:0] wd, input int mode);
        logic       old_t = turbo_en;
        logic [4:0] old_r = core_ratio;
        int n;
        irq_in = 8'hA5; dma_in = 4'hF; abort_in = 1'b1;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = wd;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R1", "busy after start", 32'(busy), 1);
        chk("R1", "clock stopped", 32'(cpu_clk_en), 0);
        chk("R3", "irq held", 32'(irq_out), 0);
        chk("R3", "dma/abort held", {27'd0, dma_out, abort_out}, 0);
        @(negedge clk);
        chk("R4", "drain_req", 32'(drain_req), 1);
        if (mode == 1) begin
            cfg_wr = 1'b1; cfg_wdata = ~wd | 7'd1;
            @(negedge clk); cfg_wr = 1'b0;
            chk("R9", "write while busy ignored", 32'(cfg_q), 32'(wd));
        end
        if (mode == 2) begin
            supply_fault = 1'b1; #1;
            chk("R8", "no sleep while busy", 32'(sleep_req), 0);
            @(negedge clk); supply_fault = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R4", "waits for drain ack", {30'd0, drain_req, sr_req}, 2);
        drain_ack = 1'b1;
        @(negedge clk); drain_ack = 1'b0;
        chk("R4", "self-refresh after drain", {30'd0, drain_req, sr_req}, 1);
        repeat (2) @(negedge clk);
        chk("R5", "no relock before sr_ack", {30'd0, pll_relock, sr_req}, 1);
        sr_ack = 1'b1;
        @(negedge clk);
        chk("R5", "relock after sr_ack", 32'(pll_relock), 1);
        if (mode == 4) begin
            repeat (TMO - 1) @(negedge clk);
            chk("R7", "no error before limit", 32'(lock_err), 0);
            @(negedge clk);
            chk("R7", "error at limit", 32'(lock_err), 1);
        end
        if (mode == 3) begin
            pll_lock = 1'b1;
            repeat (5) @(negedge clk);
            pll_lock = 1'b0;
            @(negedge clk);
            chk("R6", "glitch keeps self-refresh", 32'(sr_req), 1);
        end
        pll_lock = 1'b1;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (sr_req && n < 100);
        chk("R6", "settle cycles", 32'(n), SETTLE);
        chk("R2", "turbo held during change", {26'd0, turbo_en, core_ratio}, {26'd0, old_t, old_r});
        @(negedge clk);
        chk("R5", "clock stopped until sr_ack low", {30'd0, busy, cpu_clk_en}, 2);
        sr_ack = 1'b0;
        @(negedge clk);
        chk("R3", "clock back on last busy cycle", {30'd0, busy, cpu_clk_en}, 3);
        chk("R3", "irq held in last busy cycle", 32'(irq_out), 0);
        @(negedge clk);
        pll_lock = 1'b0;
        chk("R9", "idle after resume", 32'(busy), 0);
        chk("R9", "change bit cleared", 32'(cfg_q), 32'(wd & 7'h7E));
        chk("R2", "turbo applied", 32'(turbo_en), 32'(wd[1]));
        chk("R2", "ratio applied", 32'(core_ratio), 32'(wd[6:2]));
        chk("R3", "irq released", 32'(irq_out), 32'h A5);
        chk("R3", "dma released", 32'(dma_out), 32'hF);
        chk("R8", "replay pulse", 32'(sleep_req), (mode == 2) ? 1 : 0);
        @(negedge clk);
        chk("R8", "pulse single cycle", 32'(sleep_req), 0);
        if (mode == 4) chk("R7", "error sticky", 32'(lock_err), 1);
        irq_in = '0; dma_in = '0; abort_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_seq(7'b1010111, 0);
        t_seq(7'b0011001, 1);
        t_seq(7'b1100011, 2);
        t_seq(7'b0000101, 3);
        t_seq(7'b1111011, 4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule